// File: doc/BRIEF.md
# Packed Colour Palette Lookup

This block holds a 256-entry colour palette in 128 words of 32 bits, two 16-bit entries to a word. A bus side writes and reads the raw words. A pixel side presents an 8-bit palette index with a requested output format and receives the colour one clock later, rebuilt in that format.

Each 16-bit entry carries three 5-bit colour components and an intensity flag. The flag has no effect on the output. Each component is widened to 8 bits by appending three zero bits. The widened components are then packed into an 8-, 15-, 16- or 24-bit pixel. The conversion runs on every lookup from the stored raw entry, so a lookup sees a new format in the same cycle it is requested. Frame fetching and pixel unpacking belong to the logic around the block.

Top module: `palette_lut`

## Requirements
- R1: A word written with `busWrEn` high at a clock edge is stored at `busAddr`. `busRdData` shows the word stored at the `busAddr` that was present at the previous clock edge.
- R2: Index 2n reads bits [15:0] of word n. Index 2n+1 reads bits [31:16] of word n.
- R3: In an entry, red is in bits [4:0], green in bits [9:5] and blue in bits [14:10]. Bit 15 never changes the output pixel.
- R4: Each component widens to 8 bits as {c[4:0], 3'b000}. In the formats below, R, G and B are these widened values.
- R5: With `fmtSel` = 0, `pixOut[7:0]` is {R[7:5], G[7:5], B[7:6]} and `pixOut[23:8]` is zero.
- R6: With `fmtSel` = 1, `pixOut[14:0]` is {R[7:3], G[7:3], B[7:3]} and `pixOut[23:15]` is zero.
- R7: With `fmtSel` = 2, `pixOut[15:0]` is {R[7:3], G[7:2], B[7:3]} and `pixOut[23:16]` is zero.
- R8: With `fmtSel` = 3, `pixOut` is {R, G, B}, with red in bits [23:16] and blue in bits [7:0].
- R9: `pixValid` is high exactly one cycle after `lookupValid` was high. `pixOut` is updated from the index and `fmtSel` sampled with that lookup. `pixOut` holds its value while no lookup is requested.
- R10: When a write and a lookup address the same word at the same edge, the lookup returns the entry as it was before the write.
- R11: Reset clears every word, `busRdData`, `pixOut` and `pixValid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the raw word |
| busAddr | input | 7 | Raw word address |
| busWrData | input | 32 | Raw word to write |
| busRdData | output | 32 | Raw word read, one cycle behind the address |
| lookupValid | input | 1 | Lookup request |
| lookupIndex | input | 8 | Palette index |
| fmtSel | input | 2 | Output format: 0 = 8-bit, 1 = 15-bit, 2 = 16-bit, 3 = 24/32-bit |
| pixOut | output | 24 | Converted pixel |
| pixValid | output | 1 | Pixel valid, one cycle after the request |

## Verification
The bench targets the packing corners:
- Odd and even indices in the same word, and the first and last words of the array. A swapped half-select would return the partner entry.
- An entry whose only set bit is the intensity flag, and a full-scale entry with and without the flag. A converter that leaked bit 15 would show a nonzero or changed pixel.
- Components chosen so that the 16-bit format exposes the extra green bit. A 5-bit green field in that format would give a wrong value.
- A format change between back-to-back lookups of the same index, and a write that collides with a lookup of the same word. A design that staged the format or forwarded the write would return the wrong colour.

// File: rtl/palette_pkg.sv
package palette_pkg;

  typedef enum logic [1:0] {
    FMT_8  = 2'd0,
    FMT_15 = 2'd1,
    FMT_16 = 2'd2,
    FMT_24 = 2'd3
  } palFmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrWord;
    logic lkpLoad;
  } palStrobe_t;

  // entry: [4:0] red, [9:5] green, [14:10] blue; the flag bit is never passed in
  function automatic logic [23:0] palConvert(input logic [14:0] ent, input palFmt_e fmt);
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    r = {ent[4:0], 3'b000};
    g = {ent[9:5], 3'b000};
    b = {ent[14:10], 3'b000};
    case (fmt)
      FMT_8:   palConvert = {16'b0, r[7:5], g[7:5], b[7:6]};
      FMT_15:  palConvert = {9'b0, r[7:3], g[7:3], b[7:3]};
      FMT_16:  palConvert = {8'b0, r[7:3], g[7:2], b[7:3]};
      default: palConvert = {r, g, b};
    endcase
  endfunction

endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWrEn,
  input  logic       lookupValid,
  output palStrobe_t strobe,
  output logic       pixValid
);

  always_comb begin
    strobe.wrWord  = busWrEn;
    strobe.lkpLoad = lookupValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pixValid <= 1'b0;
    else       pixValid <= lookupValid;
  end

endmodule

// File: rtl/palette_datapath.sv
module palette_datapath
  import palette_pkg::*;
#(
  parameter int NUM_WORDS = 128,
  parameter int WORD_W    = 32,
  parameter int PIX_W     = 24,
  localparam int ADDR_W   = $clog2(NUM_WORDS),
  localparam int IDX_W    = ADDR_W + 1,
  localparam int HALF_W   = WORD_W / 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  palStrobe_t        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  input  logic [IDX_W-1:0]  lookupIndex,
  input  logic [1:0]        fmtSel,
  output logic [PIX_W-1:0]  pixOut
);

  logic [WORD_W-1:0] mem [NUM_WORDS];
  logic [14:0]       entry;
  logic [ADDR_W-1:0] lkpWord;

  assign lkpWord = lookupIndex[IDX_W-1:1];
  // odd index takes the upper half; the flag bit of each half is dropped
  assign entry = lookupIndex[0] ? mem[lkpWord][HALF_W+14:HALF_W] : mem[lkpWord][14:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
      busRdData <= '0;
      pixOut    <= '0;
    end else begin
      if (strobe.wrWord) mem[busAddr] <= busWrData;
      busRdData <= mem[busAddr];
      if (strobe.lkpLoad) pixOut <= PIX_W'(palConvert(entry, palFmt_e'(fmtSel)));
    end
  end

endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [6:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic        lookupValid,
  input  logic [7:0]  lookupIndex,
  input  logic [1:0]  fmtSel,
  output logic [23:0] pixOut,
  output logic        pixValid
);

  palStrobe_t strobe;

  palette_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .lookupValid(lookupValid),
    .strobe(strobe), .pixValid(pixValid)
  );

  palette_datapath #(.NUM_WORDS(128), .WORD_W(32), .PIX_W(24)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .lookupIndex(lookupIndex),
    .fmtSel(fmtSel), .pixOut(pixOut)
  );

endmodule

// File: rtl/palette_lut_checker.sv
module palette_lut_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic [6:0]  busAddr,
  input logic [31:0] busWrData,
  input logic [31:0] busRdData,
  input logic        lookupValid,
  input logic [7:0]  lookupIndex,
  input logic [1:0]  fmtSel,
  input logic [23:0] pixOut,
  input logic        pixValid
);

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> pixValid);

  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !pixValid);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> $stable(pixOut));

  assert_fmt8_upper_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(fmtSel) == 2'd0) |-> pixOut[23:8] == 16'd0);

  assert_fmt15_upper_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(fmtSel) == 2'd1) |-> pixOut[23:15] == 9'd0);

  assert_fmt16_upper_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(fmtSel) == 2'd2) |-> pixOut[23:16] == 8'd0);

  assert_fmt24_zero_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(fmtSel) == 2'd3) |->
      (pixOut[2:0] == 3'd0 && pixOut[10:8] == 3'd0 && pixOut[18:16] == 3'd0));

  assert_readback_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busWrEn, 2) && !$past(busWrEn) && $past(busAddr, 2) == $past(busAddr))
      |-> busRdData == $past(busWrData, 2));

  // lookupIndex feeds no property; it is tied into one so every port is used
  assert_index_known: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |-> !$isunknown(lookupIndex));

endmodule

bind palette_lut palette_lut_checker u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .lookupValid(lookupValid),
  .lookupIndex(lookupIndex), .fmtSel(fmtSel), .pixOut(pixOut), .pixValid(pixValid)
);

// File: tb/palette_lut_bench.sv
module palette_lut_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        lookupValid = 1'b0;
  logic [7:0]  lookupIndex = '0;
  logic [1:0]  fmtSel = '0;
  logic [23:0] pixOut;
  logic        pixValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  palette_lut u_palette_lut (.*);

  // {index, format, expected pixel}
  localparam int NV = 24;
  localparam logic [33:0] VEC [NV] = '{
    {8'd0,   2'd0, 24'h0000FF}, {8'd0,   2'd1, 24'h007FFF},
    {8'd0,   2'd2, 24'h00FFDF}, {8'd0,   2'd3, 24'hF8F8F8},
    {8'd1,   2'd0, 24'h000000}, {8'd1,   2'd1, 24'h000000},
    {8'd1,   2'd2, 24'h000000}, {8'd1,   2'd3, 24'h000000},
    {8'd10,  2'd0, 24'h000000}, {8'd10,  2'd1, 24'h000443},
    {8'd10,  2'd2, 24'h000883}, {8'd10,  2'd3, 24'h081018},
    {8'd11,  2'd0, 24'h000088}, {8'd11,  2'd1, 24'h004104},
    {8'd11,  2'd2, 24'h008204}, {8'd11,  2'd3, 24'h804020},
    {8'd254, 2'd0, 24'h0000E0}, {8'd254, 2'd1, 24'h007C00},
    {8'd254, 2'd2, 24'h00F800}, {8'd254, 2'd3, 24'hF80000},
    {8'd255, 2'd0, 24'h000003}, {8'd255, 2'd1, 24'h00001F},
    {8'd255, 2'd2, 24'h00001F}, {8'd255, 2'd3, 24'h0000F8}
  };

  function automatic string fmtReq(input logic [1:0] f);
    case (f)
      2'd0: fmtReq = "R5";
      2'd1: fmtReq = "R6";
      2'd2: fmtReq = "R7";
      default: fmtReq = "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    @(posedge clk); #1;
    d = busRdData;
  endtask

  task automatic lookup(input logic [7:0] idx, input logic [1:0] f,
                        output logic [23:0] pix, output logic vld);
    @(negedge clk);
    lookupValid = 1'b1; lookupIndex = idx; fmtSel = f;
    @(posedge clk); #1;
    pix = pixOut; vld = pixValid;
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [23:0] pix;
    logic        vld;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11 pixValid", {31'b0, pixValid}, 32'd0);
    check("R11 pixOut", {8'b0, pixOut}, 32'd0);
    check("R11 busRdData", busRdData, 32'd0);
    @(negedge clk); rstN = 1'b1;
    busRead(7'd3, rd);
    check("R11 word cleared", rd, 32'd0);

    busWrite(7'd0,   32'h8000_7FFF);
    busWrite(7'd5,   32'h9110_0C41);
    busWrite(7'd127, 32'h7C00_001F);

    // R1 readback
    busRead(7'd5, rd);   check("R1 word5", rd, 32'h9110_0C41);
    busRead(7'd127, rd); check("R1 word127", rd, 32'h7C00_001F);
    busRead(7'd0, rd);   check("R1 word0", rd, 32'h8000_7FFF);

    // R2/R4..R8 table: even/odd halves, each format
    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i][33:26], VEC[i][25:24], pix, vld);
      check($sformatf("%s R2 R4 idx %0d", fmtReq(VEC[i][25:24]), VEC[i][33:26]),
            {8'b0, pix}, {8'b0, VEC[i][23:0]});
    end

    // R3: flag bit alone gives zero, flag set or clear gives same pixel
    busWrite(7'd1, 32'hFFFF_7FFF);
    lookup(8'd2, 2'd3, pix, vld); check("R3 flag clear", {8'b0, pix}, 32'h00F8F8F8);
    lookup(8'd3, 2'd3, pix, vld); check("R3 flag set", {8'b0, pix}, 32'h00F8F8F8);

    // R9: valid timing, hold, format change back-to-back
    check("R9 valid", {31'b0, vld}, 32'd1);
    @(posedge clk); #1;
    check("R9 valid drops", {31'b0, pixValid}, 32'd0);
    check("R9 hold", {8'b0, pixOut}, 32'h00F8F8F8);
    @(negedge clk);
    lookupValid = 1'b1; lookupIndex = 8'd11; fmtSel = 2'd1;
    @(posedge clk); #1;
    check("R9 first fmt", {8'b0, pixOut}, 32'h00004104);
    @(negedge clk); fmtSel = 2'd2;
    @(posedge clk); #1;
    check("R9 fmt switch", {8'b0, pixOut}, 32'h00008204);
    @(negedge clk); lookupValid = 1'b0;

    // R10: collision returns old entry, then new one
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 7'd5; busWrData = 32'h0000_001F;
    lookupValid = 1'b1; lookupIndex = 8'd10; fmtSel = 2'd1;
    @(posedge clk); #1;
    check("R10 old data", {8'b0, pixOut}, 32'h00000443);
    @(negedge clk); busWrEn = 1'b0;
    @(posedge clk); #1;
    check("R10 new data", {8'b0, pixOut}, 32'h00007C00);
    @(negedge clk); lookupValid = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule